// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block is the processor-facing side of a small serial port. It maps eight byte-wide registers onto word-aligned byte addresses. Four of them return fixed identification bytes. One is a data port: a write goes to a one-entry transmit holding register, and a read pops a four-deep receive queue. One register mixes control and status, and two hold the baud divisor. The serial shift engines sit outside the block. The receive engine pushes each finished byte, together with a bad-stop-bit flag. The transmit engine takes bytes from the holding register through a take strobe.

Both directions share one level-sensitive interrupt. The receive side raises it when interrupts are enabled for receive and the queue holds data or an error flag is set. The transmit side raises it when interrupts are enabled for transmit and the holding register is free. Error flags stay set until software writes a zero into their bit positions. Software normally does this with a read-modify-write of the status register.

Top module: `uart_fe_top`

## Requirements
- R1: After reset the status register reads 0xA0, both baud bytes read 0, `baud_div` is 0, `tx_full` is 0 and `irq` is 0.
- R2: Byte addresses 0x00, 0x04, 0x08 and 0x0C return bytes 0 to 3 of the `ID_WORD` parameter, least significant first. Writes to these addresses change nothing.
- R3: Address 0x18 holds the divisor low byte and 0x1C holds the high byte. Both can be read back, and `baud_div` equals {high, low}.
- R4: A write to 0x10 while the holding register is free loads the byte onto `tx_byte`, sets `tx_full` and clears status bit 7. A `tx_take` pulse frees the register again.
- R5: A write to 0x10 while the holding register is occupied is ignored. `tx_byte` keeps the earlier byte.
- R6: A read of 0x10 returns the oldest queued byte and removes it, so bytes come out in arrival order. A read of an empty queue returns 0x00 and changes nothing.
- R7: Status bit 5 is 1 when the queue is empty. Bit 3 is 1 when it holds 4 bytes. Bit 4 is 1 when it holds exactly 3 bytes.
- R8: A push into a full queue that is not being read in the same cycle drops the byte and sets status bit 1 (overrun). A push and a read in the same cycle on a full queue is not an overrun.
- R9: A push with `rx_frame_bad` high stores the byte and sets status bit 0 (frame error).
- R10: A status write with bit 0 or bit 1 at zero clears that error flag. A one leaves the flag unchanged, and an error event in the same cycle wins over the clear.
- R11: A status write sets the receive enable from bit 2 and the transmit enable from bit 6. Bits 3, 4, 5 and 7 ignore writes, and writing a one to an error bit does not set it.
- R12: `irq` is registered. One cycle after the state changes, it equals (bit2 AND (NOT bit5 OR bit0 OR bit1)) OR (bit6 AND bit7).
- R13: With receive interrupts enabled, a set error flag raises `irq` even when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid the cycle after |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address; low two bits must be zero for a hit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_push | input | 1 | Receive engine delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_frame_bad | input | 1 | Stop bit missing on the pushed byte |
| tx_full | output | 1 | Holding register occupied |
| tx_byte | output | 8 | Byte for the transmit engine |
| tx_take | input | 1 | Transmit engine consumed the byte |
| baud_div | output | 16 | Divisor {high, low} |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench fills the receive queue to four bytes and pushes a fifth. It then checks that the fifth byte is lost and the overrun flag set. A design that overwrote the oldest entry or wrapped its pointer would return the wrong sequence on draining. The bench also pushes and reads in the same cycle on a full queue, which a design with an overly strict full test would flag as overrun. It pushes a frame error and drains the queue, so the interrupt must stay high with no data; a design that gated errors with data presence would drop it. Status writes of 0xFF and 0xFD show whether read-only bits or error bits can be forced by software, and a second data write while the holding register is busy shows whether the design overwrites `tx_byte`.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
    localparam int ADDR_W = 5;
    localparam int BYTE_W = 8;

    localparam logic [2:0] IDX_ID0    = 3'd0;
    localparam logic [2:0] IDX_ID1    = 3'd1;
    localparam logic [2:0] IDX_ID2    = 3'd2;
    localparam logic [2:0] IDX_ID3    = 3'd3;
    localparam logic [2:0] IDX_DATA   = 3'd4;
    localparam logic [2:0] IDX_STATUS = 3'd5;
    localparam logic [2:0] IDX_BAUDLO = 3'd6;
    localparam logic [2:0] IDX_BAUDHI = 3'd7;

    localparam int SB_FERR  = 0;
    localparam int SB_OERR  = 1;
    localparam int SB_RXIE  = 2;
    localparam int SB_TXIE  = 6;
endpackage

// File: rtl/uart_fe_rxq.sv
module uart_fe_rxq #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic          one_left,
    output logic          drop
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t q_d, q_q;
    logic do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d     = q_q;
        do_pop  = pop && (q_q.cnt != '0);
        do_push = push && ((q_q.cnt != FULL_CNT) || do_pop);
        drop    = push && !do_push;
        if (do_push) begin
            q_d.mem[q_q.wr] = push_data;
            q_d.wr          = bump(q_q.wr);
        end
        if (do_pop) begin
            q_d.rd = bump(q_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head     = q_q.mem[q_q.rd];
    assign empty    = (q_q.cnt == '0);
    assign full     = (q_q.cnt == FULL_CNT);
    assign one_left = (q_q.cnt == CW'(DEPTH - 1));

    // R7: occupancy never exceeds the queue depth
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= FULL_CNT);

    // R6: a read of an empty queue with no push leaves it empty
    assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

    // R8: a rejected push leaves the queue full
    assert_drop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> full);
endmodule

// File: rtl/uart_fe_txhold.sv
module uart_fe_txhold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         take,
    output logic         busy,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         busy;
        logic [W-1:0] data;
    } h_t;

    h_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (h_q.busy) begin
            if (take) begin
                h_d.busy = 1'b0;
            end
        end else if (load) begin
            h_d.busy = 1'b1;
            h_d.data = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign busy = h_q.busy;
    assign data = h_q.data;

    // R5: a load while occupied keeps the held byte
    assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && busy) |=> $stable(data));

    // R4: a take while occupied frees the register
    assert_take_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && busy) |=> !busy);
endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_ie,
    input  logic tx_ie,
    input  logic rx_empty,
    input  logic ferr,
    input  logic oerr,
    input  logic tx_empty,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = (rx_ie && (!rx_empty || ferr || oerr)) || (tx_ie && tx_empty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

    // R12: room in the transmitter with its enable set raises the line next cycle
    assert_irq_tx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie && tx_empty) |=> irq);

    // R13: an error flag alone is enough on the receive side
    assert_irq_err_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && (ferr || oerr)) |=> irq);

    // R12: with both enables clear the line drops next cycle
    assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |=> !irq);
endmodule

// File: rtl/uart_fe_top.sv
module uart_fe_top
    import uart_fe_pkg::*;
#(
    parameter logic [31:0] ID_WORD   = 32'h1A2B3C4D,
    parameter int          RX_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_frame_bad,
    output logic              tx_full,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_take,
    output logic [2*BYTE_W-1:0] baud_div,
    output logic              irq
);
    typedef struct packed {
        logic              rx_ie;
        logic              tx_ie;
        logic              ferr;
        logic              oerr;
        logic [BYTE_W-1:0] baud_lo;
        logic [BYTE_W-1:0] baud_hi;
        logic [BYTE_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic              hit;
    logic [2:0]        idx;
    logic              rxq_pop, rxq_empty, rxq_full, rxq_one, rxq_drop;
    logic [BYTE_W-1:0] rxq_head;
    logic              tx_load, tx_busy;
    logic              wr_status;
    logic [BYTE_W-1:0] status_rd;
    logic [BYTE_W-1:0] mux_rd;

    assign hit       = (bus_addr[1:0] == 2'b00);
    assign idx       = bus_addr[4:2];
    assign rxq_pop   = bus_rd && hit && (idx == IDX_DATA);
    assign tx_load   = bus_wr && hit && (idx == IDX_DATA);
    assign wr_status = bus_wr && hit && (idx == IDX_STATUS);

    uart_fe_rxq #(.DEPTH(RX_DEPTH), .W(BYTE_W)) rxq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (rxq_pop),
        .head      (rxq_head),
        .empty     (rxq_empty),
        .full      (rxq_full),
        .one_left  (rxq_one),
        .drop      (rxq_drop)
    );

    uart_fe_txhold #(.W(BYTE_W)) txh_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_data (bus_wdata),
        .take      (tx_take),
        .busy      (tx_busy),
        .data      (tx_byte)
    );

    uart_fe_irq irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_ie    (st_q.rx_ie),
        .tx_ie    (st_q.tx_ie),
        .rx_empty (rxq_empty),
        .ferr     (st_q.ferr),
        .oerr     (st_q.oerr),
        .tx_empty (!tx_busy),
        .irq      (irq)
    );

    always_comb begin
        status_rd = {!tx_busy, st_q.tx_ie, rxq_empty, rxq_one,
                     rxq_full, st_q.rx_ie, st_q.oerr, st_q.ferr};
        case (idx)
            IDX_ID0:    mux_rd = ID_WORD[7:0];
            IDX_ID1:    mux_rd = ID_WORD[15:8];
            IDX_ID2:    mux_rd = ID_WORD[23:16];
            IDX_ID3:    mux_rd = ID_WORD[31:24];
            IDX_DATA:   mux_rd = rxq_empty ? '0 : rxq_head;
            IDX_STATUS: mux_rd = status_rd;
            IDX_BAUDLO: mux_rd = st_q.baud_lo;
            IDX_BAUDHI: mux_rd = st_q.baud_hi;
            default:    mux_rd = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_status) begin
            st_d.rx_ie = bus_wdata[SB_RXIE];
            st_d.tx_ie = bus_wdata[SB_TXIE];
            if (!bus_wdata[SB_FERR]) st_d.ferr = 1'b0;
            if (!bus_wdata[SB_OERR]) st_d.oerr = 1'b0;
        end
        if (rx_push && rx_frame_bad) st_d.ferr = 1'b1;
        if (rxq_drop)                st_d.oerr = 1'b1;
        if (bus_wr && hit && (idx == IDX_BAUDLO)) st_d.baud_lo = bus_wdata;
        if (bus_wr && hit && (idx == IDX_BAUDHI)) st_d.baud_hi = bus_wdata;
        if (bus_rd && hit) st_d.rdata = mux_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign tx_full   = tx_busy;
    assign baud_div  = {st_q.baud_hi, st_q.baud_lo};

    // R8: a push into a full queue with no read sets the overrun flag
    assert_overrun_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rxq_full && !rxq_pop) |=> st_q.oerr);

    // R10: writing zero to the overrun bit clears it when no overrun coincides
    assert_oerr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !bus_wdata[SB_OERR] && !(rx_push && rxq_full && !rxq_pop))
        |=> !st_q.oerr);

    // R9: a bad-stop-bit push sets the frame error flag
    assert_ferr_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_frame_bad) |=> st_q.ferr);

    // R11: an error flag never rises without its event
    assert_ferr_only_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ferr && !(rx_push && rx_frame_bad)) |=> !st_q.ferr);
endmodule

// File: tb/uart_fe_top_tb.sv
module uart_fe_top_tb_top;
    localparam logic [31:0] ID = 32'h1A2B3C4D;

    localparam logic [2:0] OP_WR   = 3'd0;
    localparam logic [2:0] OP_RD   = 3'd1;
    localparam logic [2:0] OP_PUSH = 3'd2;
    localparam logic [2:0] OP_TAKE = 3'd3;
    localparam logic [2:0] OP_IRQ  = 3'd4;
    localparam logic [2:0] OP_TXB  = 3'd5;

    typedef struct packed {
        logic [2:0] op;
        logic [4:0] addr;
        logic [7:0] data;
        logic       bad;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 64;
    localparam vec_t VECS [NV] = '{
        '{OP_RD,   5'h00, 8'h00, 1'b0, 8'h4D, 4'd2},  // R2 id byte 0
        '{OP_WR,   5'h00, 8'hFF, 1'b0, 8'h00, 4'd2},  // R2 write ignored
        '{OP_RD,   5'h00, 8'h00, 1'b0, 8'h4D, 4'd2},  // R2
        '{OP_RD,   5'h04, 8'h00, 1'b0, 8'h3C, 4'd2},  // R2
        '{OP_RD,   5'h08, 8'h00, 1'b0, 8'h2B, 4'd2},  // R2
        '{OP_RD,   5'h0C, 8'h00, 1'b0, 8'h1A, 4'd2},  // R2
        '{OP_WR,   5'h18, 8'h34, 1'b0, 8'h00, 4'd3},  // R3
        '{OP_WR,   5'h1C, 8'h12, 1'b0, 8'h00, 4'd3},  // R3
        '{OP_RD,   5'h18, 8'h00, 1'b0, 8'h34, 4'd3},  // R3
        '{OP_RD,   5'h1C, 8'h00, 1'b0, 8'h12, 4'd3},  // R3
        '{OP_WR,   5'h10, 8'h55, 1'b0, 8'h00, 4'd4},  // R4 load
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'h20, 4'd4},  // R4 tx busy
        '{OP_TXB,  5'h00, 8'h00, 1'b0, 8'h55, 4'd4},  // R4
        '{OP_WR,   5'h10, 8'h66, 1'b0, 8'h00, 4'd5},  // R5 ignored
        '{OP_TXB,  5'h00, 8'h00, 1'b0, 8'h55, 4'd5},  // R5
        '{OP_TAKE, 5'h00, 8'h00, 1'b0, 8'h00, 4'd4},  // R4
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'hA0, 4'd4},  // R4 free again
        '{OP_PUSH, 5'h00, 8'h11, 1'b0, 8'h00, 4'd6},  // R6
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'h80, 4'd7},  // R7 one byte
        '{OP_PUSH, 5'h00, 8'h22, 1'b0, 8'h00, 4'd6},  // R6
        '{OP_PUSH, 5'h00, 8'h33, 1'b0, 8'h00, 4'd6},  // R6
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'h90, 4'd7},  // R7 three bytes
        '{OP_PUSH, 5'h00, 8'h44, 1'b0, 8'h00, 4'd6},  // R6
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'h88, 4'd7},  // R7 full
        '{OP_PUSH, 5'h00, 8'h55, 1'b0, 8'h00, 4'd8},  // R8 overrun
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'h8A, 4'd8},  // R8
        '{OP_RD,   5'h10, 8'h00, 1'b0, 8'h11, 4'd6},  // R6 oldest
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'h92, 4'd7},  // R7
        '{OP_RD,   5'h10, 8'h00, 1'b0, 8'h22, 4'd6},  // R6
        '{OP_RD,   5'h10, 8'h00, 1'b0, 8'h33, 4'd6},  // R6
        '{OP_RD,   5'h10, 8'h00, 1'b0, 8'h44, 4'd8},  // R8 fifth byte lost
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'hA2, 4'd8},  // R8 sticky
        '{OP_RD,   5'h10, 8'h00, 1'b0, 8'h00, 4'd6},  // R6 empty read
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'hA2, 4'd6},  // R6 unchanged
        '{OP_WR,   5'h14, 8'hFD, 1'b0, 8'h00, 4'd10}, // R10 clear overrun
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'hE4, 4'd11}, // R11
        '{OP_IRQ,  5'h00, 8'h00, 1'b0, 8'h01, 4'd12}, // R12 tx room
        '{OP_WR,   5'h14, 8'h04, 1'b0, 8'h00, 4'd11}, // R11
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'hA4, 4'd11}, // R11
        '{OP_IRQ,  5'h00, 8'h00, 1'b0, 8'h00, 4'd12}, // R12
        '{OP_PUSH, 5'h00, 8'h77, 1'b1, 8'h00, 4'd9},  // R9 bad stop bit
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'h85, 4'd9},  // R9
        '{OP_IRQ,  5'h00, 8'h00, 1'b0, 8'h01, 4'd12}, // R12
        '{OP_RD,   5'h10, 8'h00, 1'b0, 8'h77, 4'd9},  // R9 byte kept
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'hA5, 4'd13}, // R13
        '{OP_IRQ,  5'h00, 8'h00, 1'b0, 8'h01, 4'd13}, // R13 error, no data
        '{OP_WR,   5'h14, 8'h05, 1'b0, 8'h00, 4'd10}, // R10 one keeps
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'hA5, 4'd10}, // R10
        '{OP_WR,   5'h14, 8'h04, 1'b0, 8'h00, 4'd10}, // R10 zero clears
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'hA4, 4'd10}, // R10
        '{OP_IRQ,  5'h00, 8'h00, 1'b0, 8'h00, 4'd10}, // R10
        '{OP_WR,   5'h14, 8'h00, 1'b0, 8'h00, 4'd12}, // R12
        '{OP_PUSH, 5'h00, 8'h99, 1'b0, 8'h00, 4'd12}, // R12
        '{OP_IRQ,  5'h00, 8'h00, 1'b0, 8'h00, 4'd12}, // R12 disabled
        '{OP_WR,   5'h14, 8'hFF, 1'b0, 8'h00, 4'd11}, // R11
        '{OP_RD,   5'h14, 8'h00, 1'b0, 8'hC4, 4'd11}, // R11 ro bits hold
        '{OP_IRQ,  5'h00, 8'h00, 1'b0, 8'h01, 4'd12}, // R12
        '{OP_RD,   5'h10, 8'h00, 1'b0, 8'h99, 4'd6},  // R6
        '{OP_WR,   5'h14, 8'h40, 1'b0, 8'h00, 4'd12}, // R12
        '{OP_WR,   5'h10, 8'hAB, 1'b0, 8'h00, 4'd4},  // R4
        '{OP_IRQ,  5'h00, 8'h00, 1'b0, 8'h00, 4'd12}, // R12 tx busy
        '{OP_TXB,  5'h00, 8'h00, 1'b0, 8'hAB, 4'd4},  // R4
        '{OP_TAKE, 5'h00, 8'h00, 1'b0, 8'h00, 4'd4},  // R4
        '{OP_IRQ,  5'h00, 8'h00, 1'b0, 8'h01, 4'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_frame_bad = 1'b0;
    logic        tx_full;
    logic [7:0]  tx_byte;
    logic        tx_take = 1'b0;
    logic [15:0] baud_div;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    uart_fe_top #(.ID_WORD(ID), .RX_DEPTH(4)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .rx_push      (rx_push),
        .rx_byte      (rx_byte),
        .rx_frame_bad (rx_frame_bad),
        .tx_full      (tx_full),
        .tx_byte      (tx_byte),
        .tx_take      (tx_take),
        .baud_div     (baud_div),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, {8'h00, bus_rdata}, {8'h00, exp});
    endtask

    task automatic push(input logic [7:0] b);
        rx_push = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 irq", {15'h0, irq}, 16'h0);
        chk("R1 tx_full", {15'h0, tx_full}, 16'h0);
        chk("R1 baud_div", baud_div, 16'h0000);
        rd(5'h14, 8'hA0, "R1 status");
        rd(5'h18, 8'h00, "R1 baud lo");

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vec %0d", v.req, i);
            case (v.op)
                OP_WR: begin
                    bus_wr = 1'b1; bus_addr = v.addr; bus_wdata = v.data;
                    @(negedge clk);
                    bus_wr = 1'b0;
                end
                OP_RD: begin
                    rd(v.addr, v.exp, tag);
                end
                OP_PUSH: begin
                    rx_push = 1'b1; rx_byte = v.data; rx_frame_bad = v.bad;
                    @(negedge clk);
                    rx_push = 1'b0; rx_frame_bad = 1'b0;
                end
                OP_TAKE: begin
                    tx_take = 1'b1;
                    @(negedge clk);
                    tx_take = 1'b0;
                end
                OP_IRQ: begin
                    @(negedge clk);
                    chk(tag, {15'h0, irq}, {15'h0, v.exp[0]});
                end
                default: begin
                    @(negedge clk);
                    chk(tag, {7'h0, tx_full, tx_byte}, {8'h01, v.exp});
                end
            endcase
        end

        // R3 divisor output
        chk("R3 baud_div", baud_div, 16'h1234);

        // R8 boundary: push and read together on a full queue
        push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
        rx_push = 1'b1; rx_byte = 8'hA5;
        rd(5'h10, 8'hA1, "R8 simultaneous read");
        rx_push = 1'b0;
        rd(5'h14, 8'hC8, "R8 no overrun on push with read");
        rd(5'h10, 8'hA2, "R6 order");
        rd(5'h10, 8'hA3, "R6 order");
        rd(5'h10, 8'hA4, "R6 order");
        rd(5'h10, 8'hA5, "R6 order");

        // R1 reset in the middle of activity
        push(8'h5A);
        do_reset();
        chk("R1 irq after reset", {15'h0, irq}, 16'h0);
        chk("R1 baud after reset", baud_div, 16'h0000);
        rd(5'h14, 8'hA0, "R1 status after reset");
        rd(5'h0C, 8'h1A, "R2 id after reset");

        finish_run();
    end
endmodule